// File: doc/BRIEF.md
# Two-Stage Key Combination Detector

This block is one channel of a key-combination detector. It watches five active-low, already synchronised input levels: three keys, a power button and an AC-present line. Two programmable select masks split these inputs into a precondition set and a combo set. The precondition set must be held low for a programmed time before the channel arms. Once armed, the channel looks for a falling edge on the OR of the combo set. It then times how long the combo set stays low and issues a single-cycle detect pulse when that hold completes.

The two stages let a system tell apart a deliberate sequence, such as holding one button and then pressing a second group, from a plain multi-key press. Both hold times are the sum of a shared debounce time and a per-stage duration. Each is counted in cycles of the block clock. The detect pulse drives whatever action logic sits next to the channel.

Top module: `combo_guard`

## Requirements
- R1: Input bit order is key0 (bit 0), key1 (bit 1), key2 (bit 2), power button (bit 3), AC present (bit 4). An input counts as active when it is 0. During and right after a synchronous reset, `detect` is 0 and the channel is idle.
- R2: The precondition is met on a clock edge when every input selected in `pre_mask` is 0. The channel arms on the edge that samples the precondition met for the P-th consecutive time, where P = `debounce_time` + `pre_hold`. The sum is formed at 17 bits and does not wrap.
- R3: If the precondition is not met on any edge before detection, the channel returns to idle and both timers clear. Arming again needs a full new run of P samples.
- R4: An armed channel starts combo timing only on an edge where the previous sample had at least one `combo_mask` input at 1 and the current sample has all of them at 0. Combo inputs that are already low when the channel arms do not count.
- R5: The edge sample counts as the first low sample. `detect` is 1 in the cycle after the edge that samples the combo set all-low for the C-th consecutive time, where C = `debounce_time` + `combo_hold` at 17 bits.
- R6: If a selected combo input returns to 1 during combo timing, the timer clears and the channel waits for a new high-to-low edge.
- R7: `detect` is high for exactly one cycle per event. No further pulse can occur until the combo OR has returned to 1 and fallen again.
- R8: If `pre_mask` and `combo_mask` share any bit, the channel never arms and never pulses.
- R9: If either mask is all zeros, the channel is disabled and never pulses.
- R10: A total hold of 0 counts as 1. With both totals 0, the channel arms on the first precondition sample and pulses on the edge sample itself.
- R11: Changes to `debounce_time`, `pre_hold` and `combo_hold` take effect one clock cycle after they are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| keys_n | input | 5 | Active-low input levels in the bit order of R1 |
| pre_mask | input | 5 | Selects the inputs that form the precondition |
| combo_mask | input | 5 | Selects the inputs whose OR is timed after arming |
| debounce_time | input | 16 | Shared debounce cycle count added to both holds |
| pre_hold | input | 16 | Precondition hold duration in cycles |
| combo_hold | input | 16 | Combo hold duration in cycles |
| detect | output | 1 | Registered single-cycle detection pulse |

## Verification
The only result is `detect`. It is a register loaded on the same edge that samples the last qualifying combo input level. It is therefore visible one time unit after that edge, not an edge later. The hold totals pass through one register stage, so every new duration setting is applied under reset or during idle input cycles before it matters. The bench changes inputs one time unit after a rising edge and reads `detect` one time unit after the following edge. This makes each expected value a direct count of sampled input cycles: P samples to arm and C samples including the edge sample to pulse. The long-hold case counts past 65,536 cycles, which shows that the 17-bit totals do not wrap.

// File: rtl/combo_guard_pkg.sv
package combo_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // precondition not held
    ST_PRE   = 3'd1,  // timing the precondition hold
    ST_ARMED = 3'd2,  // waiting for a falling combo edge
    ST_COMBO = 3'd3,  // timing the combo hold
    ST_DONE  = 3'd4   // pulse issued, waiting for combo OR to rise
  } cg_state_e;

  localparam int unsigned LIM_PRE   = 0;
  localparam int unsigned LIM_COMBO = 1;
  localparam int unsigned LIM_COUNT = 2;

endpackage

// File: rtl/combo_mask_eval.sv
module combo_mask_eval #(
  parameter int unsigned NUM_IN = 5
) (
  input  logic [NUM_IN-1:0] keys_n,
  input  logic [NUM_IN-1:0] pre_mask,
  input  logic [NUM_IN-1:0] combo_mask,
  output logic              pre_met,
  output logic              combo_or,
  output logic              cfg_ok
);

  logic [NUM_IN-1:0] pre_hi;
  logic [NUM_IN-1:0] combo_hi;
  logic [NUM_IN-1:0] clash;

  // Per-input qualification, one slice per monitored line
  for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
    assign pre_hi[g]   = keys_n[g] & pre_mask[g];
    assign combo_hi[g] = keys_n[g] & combo_mask[g];
    assign clash[g]    = pre_mask[g] & combo_mask[g];
  end

  always_comb begin
    pre_met  = (pre_hi == '0);
    combo_or = |combo_hi;
    cfg_ok   = (|pre_mask) && (|combo_mask) && (clash == '0);
  end

endmodule

// File: rtl/combo_limit_calc.sv
module combo_limit_calc
  import combo_guard_pkg::*;
#(
  parameter int unsigned DUR_W = 16,
  localparam int unsigned LIM_W = DUR_W + 1
) (
  input  logic             clk,
  input  logic [DUR_W-1:0] debounce_time,
  input  logic [DUR_W-1:0] pre_hold,
  input  logic [DUR_W-1:0] combo_hold,
  output logic [LIM_W-1:0] pre_lim,
  output logic [LIM_W-1:0] combo_lim
);

  logic [DUR_W-1:0] hold_sel [LIM_COUNT];
  logic [LIM_W-1:0] lim_q    [LIM_COUNT];

  assign hold_sel[LIM_PRE]   = pre_hold;
  assign hold_sel[LIM_COMBO] = combo_hold;

  // One registered adder and clamp per stage; pure pipeline of configuration
  for (genvar g = 0; g < LIM_COUNT; g++) begin : g_lim
    logic [LIM_W-1:0] sum;
    assign sum = {1'b0, debounce_time} + {1'b0, hold_sel[g]};
    always_ff @(posedge clk) begin
      lim_q[g] <= (sum == '0) ? LIM_W'(1) : sum;
    end
  end

  assign pre_lim   = lim_q[LIM_PRE];
  assign combo_lim = lim_q[LIM_COMBO];

endmodule

// File: rtl/combo_hold_counter.sv
module combo_hold_counter #(
  parameter int unsigned CW = 17,
  localparam int unsigned EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] count_q;
  logic [EW-1:0] next_ext;

  // hit: the sample being taken now is the limit-th consecutive one
  assign next_ext = {1'b0, count_q} + EW'(1);
  assign hit      = (next_ext >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (clear && inc) begin
      count_q <= CW'(1);
    end else if (clear) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + CW'(1);
    end
  end

endmodule

// File: rtl/combo_seq_fsm.sv
module combo_seq_fsm
  import combo_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cfg_ok,
  input  logic      pre_met,
  input  logic      combo_or,
  input  logic      hit,
  output cg_state_e state,
  output logic      cnt_clear,
  output logic      cnt_inc,
  output logic      use_combo_lim,
  output logic      detect
);

  cg_state_e st_q, st_d;
  logic      prev_or_q;
  logic      detect_q, detect_d;
  logic      lost;
  logic      fall;

  assign lost = !(cfg_ok && pre_met);
  assign fall = prev_or_q && !combo_or;

  always_comb begin
    st_d      = st_q;
    cnt_clear = 1'b0;
    cnt_inc   = 1'b0;
    detect_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_clear = 1'b1;
        if (!lost) begin
          if (hit) begin
            st_d = ST_ARMED;
          end else begin
            st_d    = ST_PRE;
            cnt_inc = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (lost) begin
          st_d      = ST_IDLE;
          cnt_clear = 1'b1;
        end else if (hit) begin
          st_d      = ST_ARMED;
          cnt_clear = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_ARMED: begin
        cnt_clear = 1'b1;
        if (lost) begin
          st_d = ST_IDLE;
        end else if (fall) begin
          if (hit) begin
            st_d     = ST_DONE;
            detect_d = 1'b1;
          end else begin
            st_d    = ST_COMBO;
            cnt_inc = 1'b1;
          end
        end
      end
      ST_COMBO: begin
        if (lost) begin
          st_d      = ST_IDLE;
          cnt_clear = 1'b1;
        end else if (combo_or) begin
          st_d      = ST_ARMED;
          cnt_clear = 1'b1;
        end else if (hit) begin
          st_d      = ST_DONE;
          cnt_clear = 1'b1;
          detect_d  = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_DONE: begin
        cnt_clear = 1'b1;
        if (lost) begin
          st_d = ST_IDLE;
        end else if (combo_or) begin
          st_d = ST_ARMED;
        end
      end
      default: begin
        st_d      = ST_IDLE;
        cnt_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      prev_or_q <= 1'b0;
      detect_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      prev_or_q <= combo_or;
      detect_q  <= detect_d;
    end
  end

  assign state         = st_q;
  assign detect        = detect_q;
  assign use_combo_lim = (st_q == ST_ARMED) || (st_q == ST_COMBO);

endmodule

// File: rtl/combo_guard.sv
module combo_guard
  import combo_guard_pkg::*;
#(
  parameter int unsigned NUM_IN = 5,
  parameter int unsigned DUR_W  = 16,
  localparam int unsigned LIM_W = DUR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] keys_n,
  input  logic [NUM_IN-1:0] pre_mask,
  input  logic [NUM_IN-1:0] combo_mask,
  input  logic [DUR_W-1:0]  debounce_time,
  input  logic [DUR_W-1:0]  pre_hold,
  input  logic [DUR_W-1:0]  combo_hold,
  output logic              detect
);

  logic             pre_met;
  logic             combo_or;
  logic             cfg_ok;
  logic [LIM_W-1:0] pre_lim;
  logic [LIM_W-1:0] combo_lim;
  logic [LIM_W-1:0] cur_lim;
  logic             hit;
  logic             cnt_clear;
  logic             cnt_inc;
  logic             use_combo_lim;
  cg_state_e        fsm_state;

  combo_mask_eval #(.NUM_IN(NUM_IN)) u_eval (
    .keys_n     (keys_n),
    .pre_mask   (pre_mask),
    .combo_mask (combo_mask),
    .pre_met    (pre_met),
    .combo_or   (combo_or),
    .cfg_ok     (cfg_ok)
  );

  combo_limit_calc #(.DUR_W(DUR_W)) u_lim (
    .clk           (clk),
    .debounce_time (debounce_time),
    .pre_hold      (pre_hold),
    .combo_hold    (combo_hold),
    .pre_lim       (pre_lim),
    .combo_lim     (combo_lim)
  );

  assign cur_lim = use_combo_lim ? combo_lim : pre_lim;

  combo_hold_counter #(.CW(LIM_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clear),
    .inc   (cnt_inc),
    .limit (cur_lim),
    .hit   (hit)
  );

  combo_seq_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cfg_ok        (cfg_ok),
    .pre_met       (pre_met),
    .combo_or      (combo_or),
    .hit           (hit),
    .state         (fsm_state),
    .cnt_clear     (cnt_clear),
    .cnt_inc       (cnt_inc),
    .use_combo_lim (use_combo_lim),
    .detect        (detect)
  );

endmodule

// File: rtl/combo_guard_chk.sv
module combo_guard_chk
  import combo_guard_pkg::*;
#(
  parameter int unsigned NUM_IN = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_IN-1:0] keys_n,
  input logic [NUM_IN-1:0] pre_mask,
  input logic [NUM_IN-1:0] combo_mask,
  input logic              detect,
  input cg_state_e         state
);

  logic combo_low;
  logic pre_low;
  assign combo_low = ((keys_n & combo_mask) == '0);
  assign pre_low   = ((keys_n & pre_mask) == '0);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    detect |=> !detect);

  a_r8_overlap_silent: assert property (@(posedge clk) disable iff (rst)
    ((pre_mask & combo_mask) != '0) |=> (!detect && state == ST_IDLE));

  a_r3_drop_to_idle: assert property (@(posedge clk) disable iff (rst)
    !pre_low |=> (state == ST_IDLE && !detect));

  a_r5_detect_after_low: assert property (@(posedge clk) disable iff (rst)
    detect |-> ($past(combo_low) && $past(pre_low)));

  a_r9_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (pre_mask == '0 || combo_mask == '0) |=> !detect);

endmodule

bind combo_guard combo_guard_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .keys_n     (keys_n),
  .pre_mask   (pre_mask),
  .combo_mask (combo_mask),
  .detect     (detect),
  .state      (fsm_state)
);

// File: tb/test_combo_guard.sv
module test_combo_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NSEQ = 29;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  keys_n = 5'b11111;
  logic [4:0]  pre_mask = 5'b01000;
  logic [4:0]  combo_mask = 5'b00011;
  logic [15:0] debounce_time = 16'd1;
  logic [15:0] pre_hold = 16'd2;
  logic [15:0] combo_hold = 16'd1;
  logic        detect;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Entry: {keys_n[4:0], expected detect, requirement number}
  // Setup: power button is precondition, key0|key1 is combo, P=3, C=2
  localparam logic [9:0] SEQ [NSEQ] = '{
    {5'b11111, 1'b0, 4'd1},   // idle, R1
    {5'b10111, 1'b0, 4'd2},   // pre sample 1, R2
    {5'b10111, 1'b0, 4'd2},   // pre sample 2
    {5'b10111, 1'b0, 4'd2},   // pre sample 3 arms
    {5'b10100, 1'b0, 4'd4},   // falling edge, combo sample 1, R4
    {5'b10100, 1'b1, 4'd5},   // combo sample 2 pulses, R5
    {5'b10100, 1'b0, 4'd7},   // held low, no repeat, R7
    {5'b10101, 1'b0, 4'd7},   // OR rises
    {5'b10100, 1'b0, 4'd6},   // new edge
    {5'b10101, 1'b0, 4'd6},   // rise in window restarts, R6
    {5'b10100, 1'b0, 4'd6},   // new edge
    {5'b10100, 1'b1, 4'd6},   // full window pulses
    {5'b11111, 1'b0, 4'd3},   // precondition lost, R3
    {5'b10100, 1'b0, 4'd4},   // pre with combo already low
    {5'b10100, 1'b0, 4'd4},
    {5'b10100, 1'b0, 4'd4},   // arms, combo already low
    {5'b10100, 1'b0, 4'd4},   // no edge, no trigger
    {5'b10110, 1'b0, 4'd4},   // OR high
    {5'b10100, 1'b0, 4'd4},   // edge
    {5'b11100, 1'b0, 4'd3},   // precondition lost in window
    {5'b11111, 1'b0, 4'd3},
    {5'b10111, 1'b0, 4'd3},   // pre sample 1
    {5'b11111, 1'b0, 4'd3},   // lost, timer cleared
    {5'b10111, 1'b0, 4'd3},   // restart sample 1
    {5'b10111, 1'b0, 4'd3},   // sample 2
    {5'b10111, 1'b0, 4'd3},   // sample 3 arms
    {5'b10100, 1'b0, 4'd3},   // edge
    {5'b10100, 1'b1, 4'd3},   // pulse proves re-arm needed full hold
    {5'b11111, 1'b0, 4'd7}
  };

  combo_guard i_combo_guard (
    .clk           (clk),
    .rst           (rst),
    .keys_n        (keys_n),
    .pre_mask      (pre_mask),
    .combo_mask    (combo_mask),
    .debounce_time (debounce_time),
    .pre_hold      (pre_hold),
    .combo_hold    (combo_hold),
    .detect        (detect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: detect=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic [4:0] k);
    keys_n = k;
    @(posedge clk);
    #1;
  endtask

  task automatic hold_count(input logic [4:0] k, input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(k);
      if (detect === 1'b1) pulses++;
    end
  endtask

  task automatic do_reset();
    keys_n = 5'b11111;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int pulses;
    @(posedge clk);
    #1;
    check(detect, 1'b0, "R1 in reset");
    do_reset();
    check(detect, 1'b0, "R1 after reset");

    // Table walk
    for (int i = 0; i < NSEQ; i++) begin
      step(SEQ[i][9:5]);
      checks++;
      if (detect !== SEQ[i][4]) begin
        fails++;
        $display("FAIL R%0d table[%0d]: detect=%0b expected %0b",
                 SEQ[i][3:0], i, detect, SEQ[i][4]);
      end
    end

    // R10: zero totals clamp to one sample
    debounce_time = 16'd0; pre_hold = 16'd0; combo_hold = 16'd0;
    do_reset();
    step(5'b11111);
    step(5'b10111);
    check(detect, 1'b0, "R10 arm on first sample");
    step(5'b10100);
    check(detect, 1'b1, "R10 pulse on edge sample");
    step(5'b10100);
    check(detect, 1'b0, "R10 single pulse");

    // R8: overlapping masks never arm
    pre_mask = 5'b01001; combo_mask = 5'b00011;
    do_reset();
    step(5'b11111);
    step(5'b10110);
    step(5'b10110);
    step(5'b10100);
    check(detect, 1'b0, "R8 overlap edge");
    hold_count(5'b10100, 4, pulses);
    check(pulses != 0, 1'b0, "R8 overlap hold");

    // R9: zero precondition mask disables
    pre_mask = 5'b00000; combo_mask = 5'b00011;
    do_reset();
    step(5'b11111);
    step(5'b11100);
    check(detect, 1'b0, "R9 zero pre mask");
    hold_count(5'b11100, 3, pulses);
    check(pulses != 0, 1'b0, "R9 zero pre mask hold");

    // R9: zero combo mask disables
    pre_mask = 5'b01000; combo_mask = 5'b00000;
    do_reset();
    step(5'b11111);
    hold_count(5'b10000, 4, pulses);
    check(pulses != 0, 1'b0, "R9 zero combo mask");

    // R11: new duration applied during idle cycles; key2+AC combo, key1 precondition
    pre_mask = 5'b00010; combo_mask = 5'b10100;
    do_reset();
    debounce_time = 16'd2; pre_hold = 16'd1; combo_hold = 16'd3;  // P=3, C=5
    step(5'b11111);
    hold_count(5'b11101, 3, pulses);
    check(pulses != 0, 1'b0, "R11 arming");
    hold_count(5'b01001, 4, pulses);
    check(pulses != 0, 1'b0, "R11 four low samples");
    step(5'b01001);
    check(detect, 1'b1, "R11 fifth low sample");

    // R2 and R5: 17-bit totals, P=65536, C=32768
    pre_mask = 5'b01000; combo_mask = 5'b00011;
    debounce_time = 16'h8000; pre_hold = 16'h8000; combo_hold = 16'h0000;
    do_reset();
    step(5'b11111);
    hold_count(5'b10111, 65535, pulses);
    check(pulses != 0, 1'b0, "R2 long precondition");
    step(5'b10100);
    hold_count(5'b10100, 32770, pulses);
    check(pulses != 0, 1'b0, "R2 not armed early");
    step(5'b10111);
    step(5'b10100);
    hold_count(5'b10100, 32766, pulses);
    check(pulses != 0, 1'b0, "R5 long combo early");
    step(5'b10100);
    check(detect, 1'b1, "R5 long combo pulse");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

endmodule